// File: doc/BRIEF.md
# Dual-Copy Channel Interrupt Status Registers

This block keeps the pending-interrupt state of a two-channel disk interface controller inside a small byte-addressed configuration space. Each channel's pending flag is visible in two places: a per-channel legacy status byte and one shared mode byte that also carries a block (mask) bit per channel. The two copies are held equal at all times. Software clears a pending flag by writing a one to either copy, and the clear reaches both.

The block watches one level-sensitive interrupt line per channel. A rising level sets the channel's flag in both copies. A falling level clears it in both copies. A single interrupt output is raised while any channel is pending and not blocked. Configuration access is a 32-bit dword port with four byte enables. Byte offset N sits in dword N/4, byte lane N%4, and lane k occupies data bits 8k+7..8k. Reads are registered.

Top module: `mirror_irq_regs`

## Requirements
- R1: After reset, both pending flags and both block bits are 0, `irq_out` is 0, and reads of dwords 0x14, 0x15 and 0x1C return 0.
- R2: A 0-to-1 change on `chan_irq[c]` sets channel c's flag in both copies. Channel 0 reads at data bit 2 of dword 0x14 (offset 0x50) and at bit 10 of dword 0x1C (offset 0x71). Channel 1 reads at bit 28 of dword 0x15 (offset 0x57) and at bit 11 of dword 0x1C.
- R3: A 1-to-0 change on `chan_irq[c]` clears channel c's flag in both copies.
- R4: A write with a 1 at a legacy pending bit (dword 0x14 bit 2, or dword 0x15 bit 28, with that lane enabled) clears the flag in both the legacy byte and the mode byte. Writing a 0 there leaves the flag unchanged.
- R5: A write with a 1 at mode-byte bit 10 or bit 11 of dword 0x1C (lane 1 enabled) clears that channel's flag in both copies.
- R6: A write has no effect on a byte whose byte-enable bit is 0.
- R7: A configuration write never sets a pending flag. All other bits of the three bytes read 0 whatever is written, and writes to other dwords change nothing.
- R8: `chan_block[c]` is registered at each clock edge. It reads at bit 12 (channel 0) or bit 13 (channel 1) of dword 0x1C.
- R9: One cycle after an edge that changes the inputs, `irq_out` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), using the state that edge produced.
- R10: If a rising input and a write-one-to-clear for the same channel arrive at the same edge, the flag ends set.
- R11: The legacy copy and the mode copy of each flag are equal at every clock edge.
- R12: An input held high after its flag was cleared does not set the flag again until it falls and rises.
- R13: `cfg_rdata` takes the addressed dword at the edge where `cfg_re` is 1, using the state before that edge. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Dword address (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| chan_irq | input | 2 | Level interrupt per channel |
| chan_block | input | 2 | Block bit per channel |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The bench first steps through all sixteen combinations of the two interrupt levels and two block bits, in an order that makes both rises and falls. This separates wrong gating in the output equation from a wrong bit position in the readback. A second sweep sets both flags and then writes all-zeros, all-ones, single-bit and pair patterns to each pending byte, to an unrelated dword, and under every byte-enable mask. Reading all three bytes afterwards shows whether a clear through one copy reached the other, whether a disabled lane or a zero bit was wrongly honoured, and whether a held-high input set the flag again. Targeted cycles then place a set and a clear on the same edge, and apply writes of ones while no flag is pending.

// File: rtl/mirror_irq_pkg.sv
package mirror_irq_pkg;
  localparam int NCH     = 2;
  localparam int CFG_DW  = 32;
  localparam int CFG_BEW = CFG_DW / 8;
  localparam int CFG_AW  = 6;

  localparam logic [7:0] MODE_OFS = 8'h71;

  function automatic logic [7:0] legacy_ofs(input int ch);
    return (ch == 0) ? 8'h50 : 8'h57;
  endfunction

  function automatic int legacy_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

  function automatic int mode_pend_bit(input int ch);
    return 2 + ch;
  endfunction

  function automatic int mode_blk_bit(input int ch);
    return 4 + ch;
  endfunction

  function automatic int lane_of(input logic [7:0] ofs);
    return int'(ofs[1:0]);
  endfunction
endpackage

// File: rtl/mirror_irq_wdec.sv
module mirror_irq_wdec
  import mirror_irq_pkg::*;
(
  input  logic               we,
  input  logic [CFG_AW-1:0]  addr,
  input  logic [CFG_BEW-1:0] be,
  input  logic [CFG_DW-1:0]  wdata,
  output logic [NCH-1:0]     leg_touch,
  output logic [NCH-1:0]     leg_clr,
  output logic [NCH-1:0]     mode_touch,
  output logic [NCH-1:0]     mode_clr
);
  localparam int ML = lane_of(MODE_OFS);
  localparam logic [CFG_AW-1:0] MDW = MODE_OFS[CFG_AW+1:2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [7:0] LOFS = legacy_ofs(c);
    localparam int LL = lane_of(LOFS);
    localparam logic [CFG_AW-1:0] LDW = LOFS[CFG_AW+1:2];
    localparam int LBIT = LL * 8 + legacy_bit(c);
    localparam int MBIT = ML * 8 + mode_pend_bit(c);

    assign leg_touch[c]  = we && (addr == LDW) && be[LL];
    assign leg_clr[c]    = leg_touch[c] && wdata[LBIT];
    assign mode_touch[c] = we && (addr == MDW) && be[ML];
    assign mode_clr[c]   = mode_touch[c] && wdata[MBIT];
  end
endmodule

// File: rtl/mirror_irq_chan.sv
module mirror_irq_chan (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic leg_touch,
  input  logic leg_clr,
  input  logic mode_touch,
  input  logic mode_clr,
  output logic pend_leg,
  output logic pend_mode,
  output logic pend_nxt
);
  logic irq_q;
  logic rise, fall;
  logic leg_a, mode_a, leg_b, mode_b, leg_n, mode_n;

  assign rise = irq_in & ~irq_q;
  assign fall = ~irq_in & irq_q;

  always_comb begin
    leg_a  = leg_touch  ? (pend_leg  & ~leg_clr)  : pend_leg;
    mode_a = mode_touch ? (pend_mode & ~mode_clr) : pend_mode;
    leg_b  = mode_touch ? mode_a : leg_a;
    mode_b = leg_touch  ? leg_a  : mode_a;
    if (rise) begin
      leg_n  = 1'b1;
      mode_n = 1'b1;
    end else if (fall) begin
      leg_n  = 1'b0;
      mode_n = 1'b0;
    end else begin
      leg_n  = leg_b;
      mode_n = mode_b;
    end
  end

  assign pend_nxt = mode_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      pend_leg  <= 1'b0;
      pend_mode <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      pend_leg  <= leg_n;
      pend_mode <= mode_n;
    end
  end

  // R11
  mirror_eq_chk: assert property (@(posedge clk) disable iff (rst)
    pend_leg == pend_mode);

  // R2
  rise_set_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (pend_leg && pend_mode));

  // R3
  fall_clr_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> (!pend_leg && !pend_mode));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && (leg_clr || mode_clr)) |=> pend_mode);

  // R4
  leg_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (leg_clr && !rise) |=> (!pend_leg && !pend_mode));

  // R5
  mode_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_clr && !rise) |=> (!pend_leg && !pend_mode));
endmodule

// File: rtl/mirror_irq_rdmux.sv
module mirror_irq_rdmux
  import mirror_irq_pkg::*;
(
  input  logic [CFG_AW-1:0] addr,
  input  logic [NCH-1:0]    pend_leg,
  input  logic [NCH-1:0]    pend_mode,
  input  logic [NCH-1:0]    blk,
  output logic [CFG_DW-1:0] data
);
  localparam int ML = lane_of(MODE_OFS);
  localparam logic [CFG_AW-1:0] MDW = MODE_OFS[CFG_AW+1:2];

  always_comb begin
    data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == legacy_ofs(c)[CFG_AW+1:2])
        data[lane_of(legacy_ofs(c)) * 8 + legacy_bit(c)] = pend_leg[c];
      if (addr == MDW) begin
        data[ML * 8 + mode_pend_bit(c)] = pend_mode[c];
        data[ML * 8 + mode_blk_bit(c)]  = blk[c];
      end
    end
  end
endmodule

// File: rtl/mirror_irq_regs.sv
module mirror_irq_regs
  import mirror_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_BEW-1:0] cfg_be,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic [NCH-1:0]     chan_irq,
  input  logic [NCH-1:0]     chan_block,
  output logic               irq_out
);
  logic [NCH-1:0] leg_touch, leg_clr, mode_touch, mode_clr;
  logic [NCH-1:0] pend_leg, pend_mode, pend_nxt;
  logic [NCH-1:0] blk_q;
  logic [CFG_DW-1:0] rd_comb;

  mirror_irq_wdec u_wdec (
    .we(cfg_we), .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
    .leg_touch(leg_touch), .leg_clr(leg_clr),
    .mode_touch(mode_touch), .mode_clr(mode_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mirror_irq_chan u_chan (
      .clk(clk), .rst(rst), .irq_in(chan_irq[c]),
      .leg_touch(leg_touch[c]), .leg_clr(leg_clr[c]),
      .mode_touch(mode_touch[c]), .mode_clr(mode_clr[c]),
      .pend_leg(pend_leg[c]), .pend_mode(pend_mode[c]),
      .pend_nxt(pend_nxt[c])
    );
  end

  mirror_irq_rdmux u_rdmux (
    .addr(cfg_addr), .pend_leg(pend_leg), .pend_mode(pend_mode),
    .blk(blk_q), .data(rd_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q     <= '0;
      irq_out   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      blk_q   <= chan_block;
      irq_out <= |(pend_nxt & ~chan_block);
      if (cfg_re)
        cfg_rdata <= rd_comb;
    end
  end

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(pend_mode & ~blk_q));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_re |=> $stable(cfg_rdata));
endmodule

// File: tb/mirror_irq_regs_test.sv
module mirror_irq_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  chan_irq = '0, chan_block = '0;
  logic        irq_out;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  logic [1:0] m_pend = '0, m_prev = '0, m_blk = '0;

  always #4 clk = ~clk;

  mirror_irq_regs uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .chan_irq(chan_irq), .chan_block(chan_block),
    .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got %0d cycles, expected under 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [31:0] model_read(input logic [5:0] a);
    logic [31:0] d = '0;
    if (a == 6'h14) d[2] = m_pend[0];
    if (a == 6'h15) d[28] = m_pend[1];
    if (a == 6'h1C) begin
      d[10] = m_pend[0]; d[11] = m_pend[1];
      d[12] = m_blk[0];  d[13] = m_blk[1];
    end
    return d;
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at edge, check at next negedge
  task automatic cyc(input logic [1:0] irq, input logic [1:0] blk,
                     input logic we, input logic [5:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic re, input string rq);
    logic [31:0] exp_rd;
    logic hit0, hit1;
    chan_irq = irq; chan_block = blk;
    cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd; cfg_re = re;
    exp_rd = re ? model_read(a) : cfg_rdata;
    hit0 = we && ((a == 6'h14 && be[0] && wd[2]) || (a == 6'h1C && be[1] && wd[10]));
    hit1 = we && ((a == 6'h15 && be[3] && wd[28]) || (a == 6'h1C && be[1] && wd[11]));
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (irq[c] && !m_prev[c]) m_pend[c] = 1'b1;
      else if (!irq[c] && m_prev[c]) m_pend[c] = 1'b0;
      else if ((c == 0 && hit0) || (c == 1 && hit1)) m_pend[c] = 1'b0;
    end
    m_prev = irq; m_blk = blk;
    @(negedge clk);
    cfg_we = 1'b0; cfg_re = 1'b0;
    check(rq, "irq_out", {31'b0, irq_out}, {31'b0, |(m_pend & ~m_blk)});
    check("R13", "rdata", cfg_rdata, exp_rd);
  endtask

  task automatic read_all(input logic [1:0] irq, input logic [1:0] blk, input string rq);
    cyc(irq, blk, 1'b0, 6'h14, 4'h0, 32'h0, 1'b1, rq);
    cyc(irq, blk, 1'b0, 6'h15, 4'h0, 32'h0, 1'b1, rq);
    cyc(irq, blk, 1'b0, 6'h1C, 4'h0, 32'h0, 1'b1, rq);
  endtask

  initial begin
    logic [5:0]  addrs [4];
    logic [7:0]  pats [6];
    string       tg;
    addrs = '{6'h14, 6'h15, 6'h1C, 6'h03};
    pats  = '{8'h00, 8'hFF, 8'h04, 8'h10, 8'h08, 8'h0C};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "irq_out after reset", {31'b0, irq_out}, 32'h0);
    read_all(2'b00, 2'b00, "R1");

    // R2 R3 R8 R9: all level/block combinations, rising and falling
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 4; i++) begin
        cyc(2'(i), 2'(b), 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R9");
        read_all(2'(i), 2'(b), (i % 2 == 0) ? "R3" : "R2");
        cyc(2'(3 - i), 2'(b), 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R8");
        read_all(2'(3 - i), 2'(b), "R8");
      end

    // R4 R5 R6 R7 R12: clears through each copy under every lane mask
    for (int ai = 0; ai < 4; ai++)
      for (int be = 0; be < 16; be++)
        for (int pi = 0; pi < 6; pi++) begin
          tg = (ai < 2) ? "R4" : (ai == 2) ? "R5" : "R7";
          if (be != 15) tg = "R6";
          cyc(2'b00, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R3");
          cyc(2'b11, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R2");
          cyc(2'b11, 2'b00, 1'b1, addrs[ai], 4'(be), {4{pats[pi]}}, 1'b0, tg);
          read_all(2'b11, 2'b00, "R12");
        end

    // R7: writes of ones never set a flag
    cyc(2'b00, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R3");
    for (int ai = 0; ai < 4; ai++) begin
      cyc(2'b00, 2'b00, 1'b1, addrs[ai], 4'hF, 32'hFFFF_FFFF, 1'b0, "R7");
      read_all(2'b00, 2'b00, "R7");
    end

    // R10: rising input with clear through each copy on the same edge
    for (int ai = 0; ai < 3; ai++) begin
      cyc(2'b00, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R3");
      cyc(2'b11, 2'b00, 1'b1, addrs[ai], 4'hF, 32'hFFFF_FFFF, 1'b0, "R10");
      read_all(2'b11, 2'b00, "R10");
    end
    // one channel rises, the other is cleared on the same edge
    cyc(2'b01, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R3");
    cyc(2'b11, 2'b10, 1'b1, 6'h1C, 4'h2, 32'h0000_0C00, 1'b0, "R10");
    read_all(2'b11, 2'b10, "R10");

    // R12: after clear, flag returns only on a new rise
    cyc(2'b11, 2'b00, 1'b1, 6'h14, 4'h1, 32'h4, 1'b0, "R4");
    read_all(2'b11, 2'b00, "R12");
    cyc(2'b10, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R12");
    cyc(2'b11, 2'b00, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, "R12");
    read_all(2'b11, 2'b00, "R12");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule